// File: doc/BRIEF.md
# Staged Clock Divider Control Bank

This block holds the divide settings for fourteen clock branches of a video output subsystem. Each of seven consumers has a main branch and an auxiliary branch: VGA, picture, TV encoder, HDMI PNX, HDMI, interface and layer. Software reaches the settings through a plain 32-bit register port at two word addresses. One word also carries five general clock-select bits. The other word carries an update flag. Divider writes land in shadow fields, and the dividers only use them once they are committed.

Software commits in three steps. It writes the flag low, then writes any divider fields, then writes the flag high. On that rising edge of the flag, all fourteen shadow fields are copied into the active settings in a single cycle. The copy includes any field values carried by the same write. Every branch counter also restarts.

Each active 3-bit code drives its own enable generator. The generator emits a one-cycle clock-enable pulse every 1, 2, 4 or 8 cycles. Downstream logic uses these pulses in place of gated clocks.

Top module: `vclk_div_bank`

## Requirements
- R1: The selection word at address 0x18 holds these divider fields: VGA-aux at bits 31:29, VGA-main at 28:26, picture-main at 25:23 and picture-aux at 22:20. A read of 0x18 returns the last written shadow value of each field.
- R2: The divider word at address 0x1c holds the update flag at bit 31 and these divider fields: TV-encoder-aux 30:28, PNX-aux 27:25, PNX-main 24:22, HDMI-aux 21:19, HDMI-main 18:16, TV-encoder-main 15:13, interface-aux 11:9, interface-main 8:6, layer-aux 5:3 and layer-main 2:0. A read returns the shadow fields and the flag.
- R3: Bits 8:4 of 0x18 are plain read/write clock-select bits. They drive `clk_sel` from the cycle after the write. The other bits of 0x18 (19:9 and 3:0) read as zero.
- R4: The legal codes are 0, 1, 3 and 7. An active code of 0, 1, 3 or 7 makes its `div_en` bit pulse high for one cycle every 1, 2, 4 or 8 cycles respectively.
- R5: Shadow writes have no effect on `div_en` until a commit.
- R6: A commit happens only on a write to 0x1c that sets bit 31 while the flag is 0. Writing bit 31 as 1 while it is already 1 commits nothing.
- R7: At a commit, all fourteen active codes take the values that 0x1c and 0x18 hold after that write, and every counter restarts. Every `div_en` bit is therefore high in the cycle after the commit.
- R8: After reset, both words read zero, `clk_sel` is zero, and every `div_en` bit is high in every cycle.
- R9: Bit 12 of 0x1c reads as zero and ignores writes. Any other address reads zero, and a write to it changes nothing.
- R10: An illegal code behaves like the next larger legal code: 2 acts as 3, and 4, 5 and 6 act as 7.
- R11: Reads show shadow values before they are committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 8 | Word byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| clk_sel | output | 5 | Clock-select bits from 0x18[8:4] |
| div_en | output | 14 | Enable pulses, bit order: VGA-main, VGA-aux, pic-main, pic-aux, TVE-main, TVE-aux, PNX-main, PNX-aux, HDMI-main, HDMI-aux, INF-main, INF-aux, layer-main, layer-aux |

## Verification
The hardest state to reach is one where shadow and active settings differ while the counters are mid-period. Only the pulse trains can show that difference, and reads cannot. The bench therefore sweeps eight rotated code sets across all fourteen branches, so every branch sees all eight codes, including the illegal ones. Between the flag clear and the flag set, it watches the pulse trains to confirm the old settings still run. It then writes the flag high a second time with different fields and checks that the counter phase carries on without a restart.

// File: rtl/vdb_pkg.sv
package vdb_pkg;
   localparam int unsigned VDB_BRANCHES = 14;

   // Branch index order; equals the div_en bit order
   typedef enum int unsigned {
      BR_VGA_M = 0, BR_VGA_A, BR_PIC_M, BR_PIC_A,
      BR_TVE_M, BR_TVE_A, BR_PNX_M, BR_PNX_A,
      BR_HDM_M, BR_HDM_A, BR_INF_M, BR_INF_A,
      BR_LAY_M, BR_LAY_A
   } vdb_branch_e;

   // Field low bit inside its register word
   function automatic int unsigned vdb_lsb(int unsigned idx);
      case (idx)
         BR_VGA_M: return 26;
         BR_VGA_A: return 29;
         BR_PIC_M: return 23;
         BR_PIC_A: return 20;
         BR_TVE_M: return 13;
         BR_TVE_A: return 28;
         BR_PNX_M: return 22;
         BR_PNX_A: return 25;
         BR_HDM_M: return 16;
         BR_HDM_A: return 19;
         BR_INF_M: return 6;
         BR_INF_A: return 9;
         BR_LAY_M: return 0;
         default:  return 3;
      endcase
   endfunction

   // 1 when the field lives in the divider word, 0 for the selection word
   function automatic bit vdb_in_div(int unsigned idx);
      return idx >= BR_TVE_M;
   endfunction
endpackage

// File: rtl/vdb_regs.sv
module vdb_regs
   import vdb_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CODE_W   = 3,
   parameter int unsigned N_BR     = 14,
   parameter int unsigned SEL_LSB  = 4,
   parameter int unsigned SEL_W    = 5,
   parameter int unsigned FLAG_BIT = 31,
   parameter logic [ADDR_W-1:0] OFS_SEL = 8'h18,
   parameter logic [ADDR_W-1:0] OFS_DIV = 8'h1c
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata,
   output logic [SEL_W-1:0]         clk_sel,
   output logic [N_BR*CODE_W-1:0]   shadow_nxt,
   output logic                     commit,
   output logic                     upd_flag
);
   localparam int unsigned FLD_BITS = N_BR * CODE_W;

   if (CODE_W != 3) begin : g_bad_code
      $error("vdb_regs: field layout needs CODE_W == 3");
   end
   if (N_BR != VDB_BRANCHES) begin : g_bad_nbr
      $error("vdb_regs: N_BR must match the branch table");
   end
   if (DATA_W != 32 || FLAG_BIT >= DATA_W) begin : g_bad_data
      $error("vdb_regs: register words must be 32 bits wide");
   end
   if (SEL_LSB + SEL_W > 20) begin : g_bad_sel
      $error("vdb_regs: select bits overlap divider fields");
   end

   logic [FLD_BITS-1:0] shadow_q;
   logic [SEL_W-1:0]    sel_q;
   logic                flag_q;
   logic                hit_sel;
   logic                hit_div;
   logic [DATA_W-1:0]   word_sel;
   logic [DATA_W-1:0]   word_div;

   assign hit_sel = wr_en && (addr == OFS_SEL);
   assign hit_div = wr_en && (addr == OFS_DIV);

   for (genvar g = 0; g < N_BR; g++) begin : g_field
      localparam int unsigned LSB = vdb_lsb(g);
      if (vdb_in_div(g)) begin : g_div
         assign shadow_nxt[g*CODE_W +: CODE_W] =
            hit_div ? wdata[LSB +: CODE_W] : shadow_q[g*CODE_W +: CODE_W];
      end else begin : g_sel
         assign shadow_nxt[g*CODE_W +: CODE_W] =
            hit_sel ? wdata[LSB +: CODE_W] : shadow_q[g*CODE_W +: CODE_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         sel_q    <= '0;
         flag_q   <= 1'b0;
      end else begin
         shadow_q <= shadow_nxt;
         if (hit_sel) sel_q  <= wdata[SEL_LSB +: SEL_W];
         if (hit_div) flag_q <= wdata[FLAG_BIT];
      end
   end

   assign commit   = hit_div && wdata[FLAG_BIT] && !flag_q;
   assign upd_flag = flag_q;
   assign clk_sel  = sel_q;

   always_comb begin
      word_sel = '0;
      word_div = '0;
      for (int i = 0; i < int'(N_BR); i++) begin
         if (vdb_in_div(i))
            word_div[vdb_lsb(i) +: CODE_W] = shadow_q[i*CODE_W +: CODE_W];
         else
            word_sel[vdb_lsb(i) +: CODE_W] = shadow_q[i*CODE_W +: CODE_W];
      end
      word_sel[SEL_LSB +: SEL_W] = sel_q;
      word_div[FLAG_BIT]         = flag_q;
   end

   always_comb begin
      if (addr == OFS_SEL)      rdata = word_sel;
      else if (addr == OFS_DIV) rdata = word_div;
      else                      rdata = '0;
   end
endmodule

// File: rtl/vdb_active.sv
module vdb_active #(
   parameter int unsigned N_BR   = 14,
   parameter int unsigned CODE_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   commit,
   input  logic [N_BR*CODE_W-1:0] shadow_nxt,
   output logic [N_BR*CODE_W-1:0] act
);
   for (genvar g = 0; g < N_BR; g++) begin : g_act
      always_ff @(posedge clk) begin
         if (!rst_n)
            act[g*CODE_W +: CODE_W] <= '0;
         else if (commit)
            act[g*CODE_W +: CODE_W] <= shadow_nxt[g*CODE_W +: CODE_W];
      end
   end
endmodule

// File: rtl/vdb_tick.sv
module vdb_tick #(
   parameter int unsigned CODE_W    = 3,
   parameter bit          NORMALIZE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   if (CODE_W < 1) begin : g_bad_w
      $error("vdb_tick: CODE_W must be at least 1");
   end

   logic [CODE_W-1:0] cnt_q;
   logic [CODE_W-1:0] mask;

   if (NORMALIZE) begin : g_norm
      // fill every bit below the top set bit so odd codes act as masks
      always_comb begin
         mask[CODE_W-1] = code[CODE_W-1];
         for (int b = int'(CODE_W) - 2; b >= 0; b--)
            mask[b] = mask[b+1] | code[b];
      end
   end else begin : g_raw
      assign mask = code;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else              cnt_q <= cnt_q + CODE_W'(1);
   end

   assign tick = ~|(cnt_q & mask);
endmodule

// File: rtl/vclk_div_bank.sv
module vclk_div_bank
   import vdb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CODE_W    = 3,
   parameter int unsigned N_BR      = VDB_BRANCHES,
   parameter int unsigned SEL_LSB   = 4,
   parameter int unsigned SEL_W     = 5,
   parameter int unsigned FLAG_BIT  = 31,
   parameter bit          NORMALIZE = 1'b1,
   parameter logic [ADDR_W-1:0] OFS_SEL = 8'h18,
   parameter logic [ADDR_W-1:0] OFS_DIV = 8'h1c
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [SEL_W-1:0]  clk_sel,
   output logic [N_BR-1:0]   div_en
);
   localparam int unsigned FLD_BITS = N_BR * CODE_W;

   if (OFS_SEL == OFS_DIV) begin : g_bad_ofs
      $error("vclk_div_bank: register offsets must differ");
   end

   logic [FLD_BITS-1:0] shadow_nxt;
   logic [FLD_BITS-1:0] act_flat;
   logic                commit;
   logic                upd_flag;

   vdb_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .N_BR(N_BR),
      .SEL_LSB(SEL_LSB), .SEL_W(SEL_W), .FLAG_BIT(FLAG_BIT),
      .OFS_SEL(OFS_SEL), .OFS_DIV(OFS_DIV)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .clk_sel(clk_sel),
      .shadow_nxt(shadow_nxt), .commit(commit), .upd_flag(upd_flag)
   );

   vdb_active #(.N_BR(N_BR), .CODE_W(CODE_W)) u_active (
      .clk(clk), .rst_n(rst_n), .commit(commit),
      .shadow_nxt(shadow_nxt), .act(act_flat)
   );

   for (genvar g = 0; g < N_BR; g++) begin : g_tick
      vdb_tick #(.CODE_W(CODE_W), .NORMALIZE(NORMALIZE)) u_tick (
         .clk(clk), .rst_n(rst_n), .restart(commit),
         .code(act_flat[g*CODE_W +: CODE_W]), .tick(div_en[g])
      );
   end
endmodule

// File: rtl/vdb_checker.sv
module vdb_checker #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CODE_W  = 3,
   parameter int unsigned N_BR    = 14,
   parameter int unsigned GAP_BIT = 12,
   parameter logic [ADDR_W-1:0] OFS_DIV = 8'h1c
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   commit,
   input logic                   flag,
   input logic [N_BR*CODE_W-1:0] act,
   input logic [N_BR-1:0]        en,
   input logic [ADDR_W-1:0]      addr,
   input logic [DATA_W-1:0]      rdata
);
   AST_ACT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(act)); // R5

   AST_FLAG_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> flag); // R6

   AST_ALL_EN_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (&en)); // R7

   AST_GAP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == OFS_DIV) |-> !rdata[GAP_BIT]); // R9

   for (genvar g = 0; g < N_BR; g++) begin : g_br
      AST_DIV8_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         ((&act[g*CODE_W +: CODE_W]) && en[g] && !commit) |=> !en[g]); // R4
   end
endmodule

bind vclk_div_bank vdb_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .N_BR(N_BR),
   .GAP_BIT(12), .OFS_DIV(OFS_DIV)
) u_chk (
   .clk(clk), .rst_n(rst_n), .commit(commit), .flag(upd_flag),
   .act(act_flat), .en(div_en), .addr(bus_addr), .rdata(bus_rdata)
);

// File: tb/vclk_div_bank_tb.sv
module vclk_div_bank_tb;
   localparam logic [31:0] SEL_MASK = 32'hFFF0_01F0;
   localparam logic [31:0] DIV_MASK = 32'hFFFF_EFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [4:0]  clk_sel;
   logic [13:0] div_en;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference model state
   logic [31:0] m_selw, m_divw, nsel, ndiv;
   logic [2:0]  m_act [14];
   int unsigned mcnt;

   always #4 clk = ~clk;

   vclk_div_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_sel(clk_sel),
      .div_en(div_en)
   );

   function automatic int bpos(int i);
      int t[14] = '{26, 29, 23, 20, 13, 28, 22, 25, 16, 19, 6, 9, 0, 3};
      return t[i];
   endfunction

   function automatic bit bdiv(int i);
      return i >= 4;
   endfunction

   function automatic int period(logic [2:0] c);
      if (c == 0) return 1;
      if (c < 2)  return 2;
      if (c < 4)  return 4;
      return 8;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mcnt <= 0; m_selw <= '0; m_divw <= '0;
         for (int i = 0; i < 14; i++) m_act[i] <= '0;
      end else begin
         nsel = m_selw;
         ndiv = m_divw;
         if (bus_wr && bus_addr == 8'h18) nsel = bus_wdata & SEL_MASK;
         if (bus_wr && bus_addr == 8'h1c) ndiv = bus_wdata & DIV_MASK;
         m_selw <= nsel;
         m_divw <= ndiv;
         if (bus_wr && bus_addr == 8'h1c && bus_wdata[31] && !m_divw[31]) begin
            mcnt <= 0;
            for (int i = 0; i < 14; i++)
               m_act[i] <= bdiv(i) ? ndiv[bpos(i) +: 3] : nsel[bpos(i) +: 3];
         end else begin
            mcnt <= mcnt + 1;
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input string tag);
      logic [31:0] exp;
      bus_addr = a;
      #1;
      exp = (a == 8'h18) ? m_selw : (a == 8'h1c) ? m_divw : 32'h0;
      n_vec++;
      if (bus_rdata !== exp) begin
         n_bad++;
         $display("FAIL %s read 0x%0h: got %h exp %h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic sel_chk(input string tag);
      n_vec++;
      if (clk_sel !== m_selw[8:4]) begin
         n_bad++;
         $display("FAIL %s clk_sel: got %b exp %b", tag, clk_sel, m_selw[8:4]);
      end
   endtask

   // checks every branch pulse for n cycles, one vector per branch per cycle
   task automatic en_window(input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         for (int i = 0; i < 14; i++) begin
            logic exp;
            string t;
            exp = (mcnt % period(m_act[i])) == 0;
            t = (m_act[i] == 0 || m_act[i] == 1 || m_act[i] == 3 || m_act[i] == 7)
                ? tag : {tag, "/R10"};
            n_vec++;
            if (div_en[i] !== exp) begin
               n_bad++;
               $display("FAIL %s branch %0d code %0d cnt %0d: got %b exp %b",
                        t, i, m_act[i], mcnt, div_en[i], exp);
            end
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] sw, dw;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      rd_chk(8'h18, "R8");
      rd_chk(8'h1c, "R8");
      sel_chk("R8");
      en_window(10, "R8");

      // R1 R3 selection word layout and select bits
      wr(8'h18, 32'hFFFF_FFFF);
      rd_chk(8'h18, "R1");
      sel_chk("R3");
      wr(8'h18, 32'h0000_0150);
      rd_chk(8'h18, "R3");
      sel_chk("R3");
      // R2 R9 divider word, gap bit, flag kept low
      wr(8'h1c, 32'h7FFF_FFFF);
      rd_chk(8'h1c, "R2");
      rd_chk(8'h1c, "R9");
      en_window(8, "R5");
      // R9 unmapped address
      wr(8'h20, 32'hFFFF_FFFF);
      rd_chk(8'h20, "R9");
      rd_chk(8'h18, "R9");
      rd_chk(8'h1c, "R9");

      // R4 R7 R10 sweep of rotated codes on every branch
      for (int s = 0; s < 8; s++) begin
         sw = m_selw & 32'h0000_01F0;
         dw = '0;
         for (int i = 0; i < 14; i++) begin
            logic [2:0] c;
            c = 3'((s + i) % 8);
            if (bdiv(i)) dw[bpos(i) +: 3] = c;
            else         sw[bpos(i) +: 3] = c;
         end
         wr(8'h1c, m_divw & 32'h7FFF_FFFF);
         wr(8'h18, sw);
         rd_chk(8'h18, "R11");
         en_window(3, "R5");
         wr(8'h1c, dw | 32'h8000_0000);
         rd_chk(8'h1c, "R11");
         en_window(1, "R7");
         en_window(16, "R4");
      end

      // R6 flag already set: no second commit, phase continues
      wr(8'h18, m_selw | 32'hFFF0_0000);
      wr(8'h1c, 32'hFFFF_FFFF);
      rd_chk(8'h1c, "R6");
      en_window(12, "R6");
      // clear then set: commit of all-sevens
      wr(8'h1c, 32'h7FFF_FFFF);
      wr(8'h1c, 32'hFFFF_FFFF);
      en_window(1, "R7");
      en_window(16, "R4");

      // R8 reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rd_chk(8'h18, "R8");
      rd_chk(8'h1c, "R8");
      sel_chk("R8");
      en_window(6, "R8");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule